// File: doc/BRIEF.md
# Regulator Fault Protection Supervisor

This block is the protection controller for a single switching-regulator channel. It receives already-digitised comparator flags (output overvoltage above 115% of reference, output undervoltage below 70% of reference, control-supply lockout, die over-temperature) plus the channel enable. From these it produces driver override commands, an output-discharge enable and two latched fault status bits. The gate-drive sequencer downstream applies the override commands on top of its normal switching decisions.

Overvoltage and undervoltage are latching faults, and each one parks the power stage differently. Overvoltage clamps the output through the low-side switch. Undervoltage opens both switches and discharges the output. An undervoltage reading only counts once it has persisted for a programmable number of clocks. It is also ignored during a start-up window that restarts every time the channel is enabled. Supply lockout and over-temperature are self-recovering: they force the stage off only while they are present. Lockout, or the enable going low, is the only way to clear a latched fault. All inputs are plain level signals, and the outputs are plain levels with no handshake.

Top module: `reg_fault_supervisor`

## Requirements
- R1: After reset both fault latches are clear; with the enable high and no flag set, every override output and the discharge output are 0.
- R2: An overvoltage flag sampled at a clock edge while the enable is high and lockout is low sets the overvoltage latch at that edge. While it is latched (and no off condition is present), high-side-off = 1, low-side-on = 1, low-side-off = 0 and discharge = 0.
- R3: The undervoltage latch sets at the edge where the undervoltage flag has been sampled high on UV_DELAY_CYC consecutive armed edges. While it is latched, high-side-off = 1, low-side-off = 1, low-side-on = 0 and discharge = 1.
- R4: An edge at which the undervoltage flag is sampled low restarts the persistence count from zero.
- R5: Undervoltage samples are ignored until BLANK_CYC edges with enable high and lockout low have passed since reset, since the last enable rising edge, or since lockout was last present.
- R6: Both latches hold after the flags drop, and they clear at the first edge at which enable is low or lockout is high.
- R7: Lockout high forces high-side-off = 1, low-side-off = 1, low-side-on = 0 and discharge = 1 in the same cycle. Nothing of it remains once it drops, apart from the cleared latches and a restarted blanking window.
- R8: Over-temperature forces both switches off with discharge = 1 only while it is present. It neither sets nor clears a latch.
- R9: Enable low forces both switches off with discharge = 1.
- R10: A latch can only set while neither latch is set. If overvoltage and an undervoltage trip arrive at the same edge, only the overvoltage latch sets.
- R11: Low-side-on is never 1 together with low-side-off or with discharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| chan_en_i | input | 1 | channel enable |
| ov_flag_i | input | 1 | output overvoltage comparator flag |
| uv_flag_i | input | 1 | output undervoltage comparator flag |
| lockout_i | input | 1 | control-supply undervoltage lockout |
| overtemp_i | input | 1 | die over-temperature flag |
| hs_off_o | output | 1 | force high-side switch off |
| ls_on_o | output | 1 | force low-side switch on |
| ls_off_o | output | 1 | force low-side switch off |
| discharge_o | output | 1 | enable output discharge path |
| ov_latched_o | output | 1 | overvoltage fault latched |
| uv_latched_o | output | 1 | undervoltage fault latched |

## Verification
The bench runs with a short delay of 4 clocks and a blanking window of 6 clocks. It sweeps undervoltage pulse lengths from 1 to 7 edges after arming, which separates an off-by-one in the persistence count from a correct trip, and it repeats the sweep with a one-edge gap to show the count restarts. It raises the undervoltage flag together with the enable so the trip lands exactly at blanking plus delay, which separates a missing or short blanking window from a correct one. It then crosses the three latch states (none, overvoltage, undervoltage) with every combination of enable, lockout and over-temperature. Each case checks the override decode in the same cycle and whether the latch survived the next edge, which separates latching from self-recovering faults.

// File: rtl/fault_sup_pkg.sv
package fault_sup_pkg;

  // stage command bundle driven to the gate-drive sequencer
  typedef struct packed {
    logic hs_off;
    logic ls_on;
    logic ls_off;
    logic discharge;
  } stage_cmd_t;

  function automatic stage_cmd_t decode_cmd(input logic off_now,
                                            input logic ov_q,
                                            input logic uv_q);
    stage_cmd_t c;
    c.hs_off    = off_now | ov_q | uv_q;
    c.ls_on     = ~off_now & ov_q;
    c.ls_off    = off_now | uv_q;
    c.discharge = off_now | uv_q;
    return c;
  endfunction

endpackage

// File: rtl/fault_blank_timer.sv
module fault_blank_timer #(
  parameter int unsigned BLANK_CYC = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic armed_o
);
  localparam int unsigned BW = $clog2(BLANK_CYC + 1);
  localparam logic [BW-1:0] BLIM = BW'(BLANK_CYC);

  logic [BW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (cnt_q != BLIM) cnt_q <= cnt_q + 1'b1;
  end

  assign armed_o = (cnt_q == BLIM);

  // R5
  blank_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !armed_o);

endmodule

// File: rtl/fault_uv_qualifier.sv
module fault_uv_qualifier #(
  parameter int unsigned UV_DELAY_CYC = 3000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_i,
  output logic trip_o
);
  localparam int unsigned CW = $clog2(UV_DELAY_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(UV_DELAY_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign trip_o = sample_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (!sample_i || trip_o) cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  // R4
  uv_gap_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_i |=> (cnt_q == '0));

  // R3
  uv_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/fault_latch_pair.sv
module fault_latch_pair (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic set_ov_i,
  input  logic set_uv_i,
  output logic ov_q_o,
  output logic uv_q_o
);
  logic ov_q, uv_q, idle;

  assign idle = ~ov_q & ~uv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
      uv_q <= 1'b0;
    end else if (clr_i) begin
      ov_q <= 1'b0;
      uv_q <= 1'b0;
    end else begin
      if (idle && set_ov_i)              ov_q <= 1'b1;
      if (idle && set_uv_i && !set_ov_i) uv_q <= 1'b1;
    end
  end

  assign ov_q_o = ov_q;
  assign uv_q_o = uv_q;

  // R6
  latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (!ov_q && !uv_q));

  // R10
  single_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ov_q && uv_q));

  // R6
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_q && !clr_i) |=> ov_q);

endmodule

// File: rtl/reg_fault_supervisor.sv
module reg_fault_supervisor
  import fault_sup_pkg::*;
#(
  parameter int unsigned UV_DELAY_CYC = 3000,
  parameter int unsigned BLANK_CYC    = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chan_en_i,
  input  logic ov_flag_i,
  input  logic uv_flag_i,
  input  logic lockout_i,
  input  logic overtemp_i,
  output logic hs_off_o,
  output logic ls_on_o,
  output logic ls_off_o,
  output logic discharge_o,
  output logic ov_latched_o,
  output logic uv_latched_o
);
  logic run, armed, uv_sample, uv_trip, ov_q, uv_q, off_now;
  stage_cmd_t cmd;

  // channel allowed to run and to detect latching faults
  assign run = chan_en_i & ~lockout_i;

  fault_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (run),
    .armed_o (armed)
  );

  assign uv_sample = uv_flag_i & armed & run & ~ov_q & ~uv_q;

  fault_uv_qualifier #(.UV_DELAY_CYC(UV_DELAY_CYC)) u_uvq (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample_i (uv_sample),
    .trip_o   (uv_trip)
  );

  fault_latch_pair u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (~run),
    .set_ov_i (ov_flag_i & run),
    .set_uv_i (uv_trip),
    .ov_q_o   (ov_q),
    .uv_q_o   (uv_q)
  );

  assign off_now = ~run | overtemp_i;
  assign cmd     = decode_cmd(off_now, ov_q, uv_q);

  assign hs_off_o     = cmd.hs_off;
  assign ls_on_o      = cmd.ls_on;
  assign ls_off_o     = cmd.ls_off;
  assign discharge_o  = cmd.discharge;
  assign ov_latched_o = ov_q;
  assign uv_latched_o = uv_q;

  // R11
  ls_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ls_on_o && (ls_off_o || discharge_o)));

  // R5
  uv_blanked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !uv_q) |=> !uv_q);

  // R7
  lockout_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lockout_i |-> (hs_off_o && ls_off_o && discharge_o));

  // R8
  overtemp_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overtemp_i && run && ov_q) |=> ov_q);

endmodule

// File: tb/reg_fault_supervisor_tb.sv
module reg_fault_supervisor_tb;
  localparam int DLY = 4;
  localparam int BLK = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 0, ov = 0, uv = 0, lk = 0, ot = 0;
  logic hs_off, ls_on, ls_off, dis, ovl, uvl;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  reg_fault_supervisor #(.UV_DELAY_CYC(DLY), .BLANK_CYC(BLK)) u_dut (
    .clk(clk), .rst_n(rst_n), .chan_en_i(en), .ov_flag_i(ov),
    .uv_flag_i(uv), .lockout_i(lk), .overtemp_i(ot),
    .hs_off_o(hs_off), .ls_on_o(ls_on), .ls_off_o(ls_off),
    .discharge_o(dis), .ov_latched_o(ovl), .uv_latched_o(uvl)
  );

  // packed as {hs_off, ls_on, ls_off, discharge, ov_latched, uv_latched}
  function automatic logic [5:0] expv(logic e, logic l, logic t,
                                      logic o, logic u);
    logic off;
    off = !e | l | t;
    return {off | o | u, !off & o, off | u, off | u, o, u};
  endfunction

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic look(); #3; endtask

  task automatic chk(string req, logic [5:0] act, logic [5:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b want %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [5:0] outs();
    return {hs_off, ls_on, ls_off, dis, ovl, uvl};
  endfunction

  // clear latches, restart blanking, wait until armed
  task automatic arm();
    en = 0; ov = 0; uv = 0; lk = 0; ot = 0;
    tick();
    en = 1;
    repeat (BLK) tick();
  endtask

  task automatic make_state(int s);
    arm();
    if (s == 1) begin ov = 1; tick(); ov = 0; end
    if (s == 2) begin uv = 1; repeat (DLY) tick(); uv = 0; end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hung want finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    look();
    // R1 reset state, enable low -> R9 off/discharge
    chk("R1/R9 reset en low", outs(), expv(0, 0, 0, 0, 0));
    tick(); en = 1; look();
    chk("R1 enabled idle", outs(), expv(1, 0, 0, 0, 0));

    // R5 blanking: uv raised with enable, trip exactly at BLK+DLY edges
    en = 0; tick();
    en = 1; uv = 1;
    repeat (BLK + DLY - 1) tick();
    look();
    chk("R5 still blanked/qualifying", outs(), expv(1, 0, 0, 0, 0));
    tick(); look();
    chk("R5/R3 trip after blank+delay", outs(), expv(1, 0, 0, 0, 1));
    uv = 0;

    // R5 restart on enable rising edge
    en = 0; tick(); en = 1; uv = 1;
    repeat (BLK + DLY - 1) tick();
    look();
    chk("R5 blank restart", outs(), expv(1, 0, 0, 0, 0));
    uv = 0;

    // R3 pulse length sweep
    for (int len = 1; len <= DLY + 3; len++) begin
      arm();
      uv = 1;
      repeat (len) tick();
      uv = 0;
      look();
      chk("R3 pulse sweep", outs(), expv(1, 0, 0, 0, (len >= DLY)));
      tick(); look();
      chk("R6 uv hold", outs(), expv(1, 0, 0, 0, (len >= DLY)));
    end

    // R4 gap restarts count
    arm();
    uv = 1; repeat (DLY - 1) tick();
    uv = 0; tick();
    uv = 1; repeat (DLY - 1) tick();
    look();
    chk("R4 gap no trip", outs(), expv(1, 0, 0, 0, 0));
    tick(); look();
    chk("R4 trip after full run", outs(), expv(1, 0, 0, 0, 1));
    uv = 0;

    // R10 same-edge tie, overvoltage wins
    arm();
    uv = 1; repeat (DLY - 1) tick();
    ov = 1; tick(); ov = 0; uv = 0; look();
    chk("R10 tie ov wins", outs(), expv(1, 0, 0, 1, 0));
    // R10 latched ov blocks later uv
    uv = 1; repeat (DLY + 2) tick(); uv = 0; look();
    chk("R10 ov blocks uv", outs(), expv(1, 0, 0, 1, 0));
    // R10 latched uv blocks later ov
    make_state(2);
    ov = 1; tick(); ov = 0; look();
    chk("R10 uv blocks ov", outs(), expv(1, 0, 0, 0, 1));

    // R2 overvoltage before blanking ends still latches
    en = 0; tick(); en = 1; ov = 1; tick(); ov = 0; look();
    chk("R2 ov not blanked", outs(), expv(1, 0, 0, 1, 0));

    // decode and latch-retention sweep: state x enable x lockout x overtemp
    for (int s = 0; s < 3; s++) begin
      for (int c = 0; c < 8; c++) begin
        logic e, l, t, o, u, keep;
        make_state(s);
        o = (s == 1); u = (s == 2);
        look();
        chk(s == 1 ? "R2 ov decode" : (s == 2 ? "R3 uv decode" : "R1 idle"),
            outs(), expv(1, 0, 0, o, u));
        tick();
        e = c[2]; l = c[1]; t = c[0];
        en = e; lk = l; ot = t;
        look();
        chk(l ? "R7 lockout decode" : (t ? "R8 overtemp decode" :
            (!e ? "R9 enable low decode" : "R11 decode")),
            outs(), expv(e, l, t, o, u));
        tick();
        keep = e && !l;
        en = 1; lk = 0; ot = 0;
        look();
        chk(keep ? "R6/R8 latch kept" : "R6/R7 latch cleared",
            outs(), expv(1, 0, 0, o & keep, u & keep));
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule